// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of five prioritised localities owns a shared register interface. Each locality sees its own 4 KiB register window, chosen by address bits [14:12], and at offset 0x000 of that window it finds one access byte. Software uses that byte to ask for the interface, give it up, take it from a lower-numbered owner, and clear the flag that records it was preempted. The same byte reports whether the locality owns the interface, whether it was preempted, whether it has a request waiting, and whether any other locality has a request waiting.

Writes take effect on the clock edge. Reads are combinational from the current address. The index of the owning locality and a valid flag go out to downstream logic, which uses them to gate status and data-buffer accesses. A two-state machine holds the ownership: `ST_IDLE` means nobody owns the interface and `ST_OWNED` means one locality does. It has these transitions. Grant (`ST_IDLE`→`ST_OWNED`) happens on a request. Handoff (`ST_OWNED`→`ST_OWNED`) happens on a release when a request is waiting, or on an upward seize. Drop (`ST_OWNED`→`ST_IDLE`) happens on a release when no request is waiting.

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality owns the interface, `owner_valid` is 0, and the access byte of every locality 0..4 reads 0x81.
- R2: The locality index is `bus_addr[14:12]`. Only offset 0x000 of windows 0..4 decodes to an access byte. Reads of any other offset, or of a window numbered 5..7, return 0x00. Writes there change nothing.
- R3: The access byte reads as follows. Bit 7 is always 1. Bit 5 is 1 when this locality owns the interface. Bit 4 is the sticky preempted flag. Bit 3 reads 0. Bit 2 is 1 when any locality other than this one has a request waiting. Bit 1 is this locality's own waiting request. Bit 0 is always 1.
- R4: Writing 0x02 (request) while idle grants that locality at once: its bit 5 reads 1, its bit 1 reads 0, `owner_valid` is 1 and `owner_idx` is its index. A request from the owner itself changes nothing.
- R5: Writing 0x02 while a different locality owns the interface sets the writer's bit 1. Ownership does not change.
- R6: Writing 0x20 (release) from the owner passes ownership to the highest-numbered locality with a waiting request and clears that request. If no request is waiting the interface goes idle. A release from a non-owner has no effect.
- R7: Writing 0x08 (seize) from a locality numbered higher than the owner makes it the owner at once. It also sets bit 4 of the previous owner and clears the new owner's waiting request.
- R8: A seize from a locality numbered lower than or equal to the owner, or a seize while idle, changes no ownership, request or flag.
- R9: Writing 0x10 to a locality clears its bit 4. Nothing else changes.
- R10: A write is a command only when exactly one of bits 5, 4, 3 and 1 is set. Any other write, including one that sets only bits 7, 2 or 0, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 15 | Byte address; [14:12] locality, [11:0] window offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| owner_valid | output | 1 | Some locality owns the interface |
| owner_idx | output | 3 | Index of the owning locality (0 when idle) |

## Verification
The assertions assume that each write strobe lasts exactly one clock and carries one decoded command. They also assume that a write to an undecoded window or offset never reaches the state machine, so every command a property sees names a locality 0..4. The bench changes inputs only on the falling edge, holds the strobe for one cycle, and reads back after the rising edge. Its random phase covers out-of-range windows, non-zero offsets and arbitrary data bytes, so the decoder filters these out before they can violate the state machine's assumptions. Its directed phase walks through grant, queued request, blocked and successful seize, flag clearing and ordered handoff.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
    localparam int BIT_REG_VALID = 7;
    localparam int BIT_ACTIVE    = 5;
    localparam int BIT_SEIZED    = 4;
    localparam int BIT_SEIZE     = 3;
    localparam int BIT_PENDING   = 2;
    localparam int BIT_REQUEST   = 1;
    localparam int BIT_ESTAB     = 0;

    localparam logic [7:0] CMD_MASK = 8'((1 << BIT_ACTIVE) | (1 << BIT_SEIZED) |
                                         (1 << BIT_SEIZE)  | (1 << BIT_REQUEST));

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_OWNED
    } arb_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_REQUEST,
        OP_RELEASE,
        OP_SEIZE,
        OP_CLEAR
    } arb_op_e;
endpackage

// File: rtl/loc_arb_decode.sv
module loc_arb_decode
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC   = 5,
    parameter int WIN_SHIFT = 12,
    parameter int LOC_W     = 3,
    parameter int ADDR_W    = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [7:0]        wdata,
    output logic              hit,
    output logic [LOC_W-1:0]  loc,
    output arb_op_e           op
);
    logic [7:0] cmd_bits;
    arb_op_e    op_raw;

    assign loc = addr[ADDR_W-1:WIN_SHIFT];
    assign hit = (addr[WIN_SHIFT-1:0] == '0) && (loc < LOC_W'(NUM_LOC));
    assign cmd_bits = wdata & CMD_MASK;

    always_comb begin
        case (cmd_bits)
            8'(1 << BIT_REQUEST): op_raw = OP_REQUEST;
            8'(1 << BIT_ACTIVE):  op_raw = OP_RELEASE;
            8'(1 << BIT_SEIZE):   op_raw = OP_SEIZE;
            8'(1 << BIT_SEIZED):  op_raw = OP_CLEAR;
            default:              op_raw = OP_NONE;
        endcase
    end

    assign op = (we && hit) ? op_raw : OP_NONE;
endmodule

// File: rtl/loc_arb_pick.sv
module loc_arb_pick #(
    parameter int N = 5,
    parameter int W = 3
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/loc_arb_fsm.sv
module loc_arb_fsm
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  arb_op_e            op,
    input  logic [LOC_W-1:0]   loc,
    output logic               owner_valid,
    output logic [LOC_W-1:0]   owner_idx,
    output logic [NUM_LOC-1:0] req_q,
    output logic [NUM_LOC-1:0] seized_q
);
    arb_state_e         state_q, state_d;
    logic [LOC_W-1:0]   owner_q, owner_d;
    logic [NUM_LOC-1:0] req_d, seized_d;
    logic               pick_found;
    logic [LOC_W-1:0]   pick_idx;

    loc_arb_pick #(.N(NUM_LOC), .W(LOC_W)) u_pick (
        .vec   (req_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            owner_q  <= '0;
            req_q    <= '0;
            seized_q <= '0;
        end else begin
            state_q  <= state_d;
            owner_q  <= owner_d;
            req_q    <= req_d;
            seized_q <= seized_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        owner_d  = owner_q;
        req_d    = req_q;
        seized_d = seized_q;
        if (op == OP_CLEAR) begin
            seized_d[loc] = 1'b0;
        end
        unique case (state_q)
            ST_IDLE: begin
                if (op == OP_REQUEST) begin
                    state_d    = ST_OWNED;
                    owner_d    = loc;
                    req_d[loc] = 1'b0;
                end
            end
            ST_OWNED: begin
                case (op)
                    OP_REQUEST: begin
                        if (loc != owner_q) req_d[loc] = 1'b1;
                    end
                    OP_RELEASE: begin
                        if (loc == owner_q) begin
                            if (pick_found) begin
                                owner_d         = pick_idx;
                                req_d[pick_idx] = 1'b0;
                            end else begin
                                state_d = ST_IDLE;
                                owner_d = '0;
                            end
                        end
                    end
                    OP_SEIZE: begin
                        if (loc > owner_q) begin
                            seized_d[owner_q] = 1'b1;
                            owner_d           = loc;
                            req_d[loc]        = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        owner_valid = (state_q == ST_OWNED);
        owner_idx   = owner_q;
    end

    AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && op == OP_REQUEST) |=> (state_q == ST_OWNED && owner_q == $past(loc))); // R4
    AST_OWNER_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWNED) |-> !req_q[owner_q]); // R4
    AST_FOREIGN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWNED && op == OP_REQUEST && loc != owner_q) |=> (req_q[$past(loc)] && $stable(owner_q))); // R5
    AST_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWNED && op == OP_RELEASE && loc == owner_q && req_q == '0) |=> (state_q == ST_IDLE)); // R6
    AST_SEIZE_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWNED && op == OP_SEIZE && loc > owner_q) |=> (owner_q == $past(loc) && seized_q[$past(owner_q)])); // R7
    AST_SEIZE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SEIZE && !(state_q == ST_OWNED && loc > owner_q)) |=> ($stable(owner_q) && $stable(state_q) && $stable(req_q) && $stable(seized_q))); // R8
    AST_SEIZED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> !seized_q[$past(loc)]); // R9
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
    import loc_arb_pkg::*;
#(
    parameter  int NUM_LOC   = 5,
    parameter  int WIN_SHIFT = 12,
    localparam int LOC_W     = $clog2(NUM_LOC + 1),
    localparam int ADDR_W    = WIN_SHIFT + LOC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              owner_valid,
    output logic [LOC_W-1:0]  owner_idx
);
    logic               hit;
    logic [LOC_W-1:0]   loc;
    arb_op_e            op;
    logic [NUM_LOC-1:0] req_q, seized_q, others_req;

    loc_arb_decode #(
        .NUM_LOC(NUM_LOC), .WIN_SHIFT(WIN_SHIFT), .LOC_W(LOC_W), .ADDR_W(ADDR_W)
    ) u_decode (
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .hit   (hit),
        .loc   (loc),
        .op    (op)
    );

    loc_arb_fsm #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .loc         (loc),
        .owner_valid (owner_valid),
        .owner_idx   (owner_idx),
        .req_q       (req_q),
        .seized_q    (seized_q)
    );

    always_comb begin
        for (int i = 0; i < NUM_LOC; i++) begin
            others_req[i] = req_q[i] && (LOC_W'(i) != loc);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[BIT_REG_VALID] = 1'b1;
            bus_rdata[BIT_ACTIVE]    = owner_valid && (owner_idx == loc);
            bus_rdata[BIT_SEIZED]    = seized_q[loc];
            bus_rdata[BIT_PENDING]   = |others_req;
            bus_rdata[BIT_REQUEST]   = req_q[loc];
            bus_rdata[BIT_ESTAB]     = 1'b1;
        end
    end
endmodule

// File: tb/tb_loc_arbiter.sv
`timescale 1ns/1ps
module tb_loc_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        owner_valid;
    logic [2:0]  owner_idx;

    int checks = 0;
    int errors = 0;

    logic       m_own_v;
    logic [2:0] m_own;
    logic [4:0] m_req;
    logic [4:0] m_seized;

    always #2 clk = ~clk;

    loc_arbiter dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .owner_valid(owner_valid), .owner_idx(owner_idx)
    );

    function automatic logic [7:0] exp_byte(input logic [2:0] l, input logic [11:0] off);
        logic [7:0] b;
        logic [4:0] others;
        b = 8'h00;
        if (off == 12'h000 && l < 3'd5) begin
            others = m_req;
            others[l] = 1'b0;
            b[7] = 1'b1;
            b[5] = m_own_v && (m_own == l);
            b[4] = m_seized[l];
            b[2] = |others;
            b[1] = m_req[l];
            b[0] = 1'b1;
        end
        return b;
    endfunction

    task automatic model_apply(input logic [2:0] l, input logic [11:0] off, input logic [7:0] d);
        logic [7:0] c;
        c = d & 8'h3A;
        if (off != 12'h000 || l >= 3'd5) return;
        if (c == 8'h02) begin
            if (!m_own_v) begin m_own_v = 1'b1; m_own = l; m_req[l] = 1'b0; end
            else if (m_own != l) m_req[l] = 1'b1;
        end else if (c == 8'h20) begin
            if (m_own_v && m_own == l) begin
                if (m_req == 5'd0) begin m_own_v = 1'b0; m_own = 3'd0; end
                else begin
                    for (int i = 4; i >= 0; i--) begin
                        if (m_req[i]) begin m_own = 3'(i); m_req[i] = 1'b0; break; end
                    end
                end
            end
        end else if (c == 8'h08) begin
            if (m_own_v && l > m_own) begin
                m_seized[m_own] = 1'b1; m_own = l; m_req[l] = 1'b0;
            end
        end else if (c == 8'h10) begin
            m_seized[l] = 1'b0;
        end
    endtask

    task automatic wr(input logic [2:0] l, input logic [11:0] off, input logic [7:0] d);
        @(negedge clk);
        bus_addr = {l, off}; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_apply(l, off, d);
    endtask

    task automatic chk(input logic [2:0] l, input logic [11:0] off, input string tag);
        logic [7:0] e;
        bus_addr = {l, off};
        #0.5;
        e = exp_byte(l, off);
        checks++;
        if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s loc %0d off %h rdata actual %h expected %h", tag, l, off, bus_rdata, e);
        end
    endtask

    task automatic chk_owner(input string tag);
        checks++;
        if (owner_valid !== m_own_v || (m_own_v && owner_idx !== m_own)) begin
            errors++;
            $display("FAIL %s owner actual %b/%0d expected %b/%0d", tag, owner_valid, owner_idx, m_own_v, m_own);
        end
    endtask

    task automatic chk_all(input string tag);
        for (int i = 0; i < 5; i++) chk(3'(i), 12'h000, tag);
        chk_owner(tag);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [2:0] l;
        logic [11:0] off;
        m_own_v = 1'b0; m_own = 3'd0; m_req = '0; m_seized = '0;
        void'($urandom(32'h1C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1");
        chk(3'd3, 12'h000, "R1");
        checks++; if (bus_rdata !== 8'h81) begin errors++; $display("FAIL R1 idle byte actual %h expected 81", bus_rdata); end

        wr(3'd2, 12'h000, 8'h02); chk_all("R4");
        chk(3'd2, 12'h000, "R4");
        checks++; if (bus_rdata !== 8'hA1) begin errors++; $display("FAIL R4 grant actual %h expected a1", bus_rdata); end
        wr(3'd2, 12'h000, 8'h02); chk_all("R4");
        wr(3'd0, 12'h000, 8'h02); chk_all("R5");
        chk(3'd2, 12'h000, "R3");
        checks++; if (bus_rdata !== 8'hA5) begin errors++; $display("FAIL R3 owner pending actual %h expected a5", bus_rdata); end
        wr(3'd0, 12'h000, 8'h08); chk_all("R8");
        wr(3'd2, 12'h000, 8'h08); chk_all("R8");
        wr(3'd3, 12'h000, 8'h08); chk_all("R7");
        chk(3'd2, 12'h000, "R7");
        checks++; if (bus_rdata !== 8'h95) begin errors++; $display("FAIL R7 seized byte actual %h expected 95", bus_rdata); end
        wr(3'd2, 12'h000, 8'h10); chk_all("R9");
        wr(3'd3, 12'h000, 8'h22); chk_all("R10");
        wr(3'd1, 12'h000, 8'h85); chk_all("R10");
        wr(3'd1, 12'h004, 8'h02); chk_all("R2");
        chk(3'd1, 12'h004, "R2");
        chk(3'd6, 12'h000, "R2");
        wr(3'd5, 12'h000, 8'h08); chk_all("R2");
        wr(3'd1, 12'h000, 8'h02); chk_all("R5");
        wr(3'd0, 12'h000, 8'h20); chk_all("R6");
        wr(3'd3, 12'h000, 8'h20); chk_all("R6");
        wr(3'd1, 12'h000, 8'h20); chk_all("R6");
        wr(3'd0, 12'h000, 8'h20); chk_all("R6");
        wr(3'd4, 12'h000, 8'h08); chk_all("R8");

        for (int n = 0; n < 3000; n++) begin
            case ($urandom % 7)
                0, 1: d = 8'h02;
                2:    d = 8'h20;
                3:    d = 8'h08;
                4:    d = 8'h10;
                default: d = 8'($urandom);
            endcase
            l = 3'($urandom % 6);
            off = ($urandom % 10 == 0) ? 12'($urandom) : 12'h000;
            wr(l, off, d);
            chk_all("R3");
            chk(l, off, "R2");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule